// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Interface

This block is the byte-wide register front end of an analog output module that drives one or two 16-bit converters. A host writes each channel's output word as two bytes into holding registers, low byte and then high byte, and the word reaches the converter port only when the host writes a strobe address. Each channel has its own strobe address. A shared strobe address loads both channels on the same clock edge, so two outputs can move together.

The converter words are 16-bit two's complement. After reset every register is zero, which is mid-scale. A parameter selects a one-channel or a two-channel build. An identification byte at offset 0x00 reports which build is present. Reads return data one cycle after the read request, and every address other than the identification offset reads as zero. In the one-channel build the second channel's addresses do nothing, and the shared strobe only loads channel 0.

Top module: `dac_bank_regif`

## Requirements
- R1: After a synchronous active-low reset, both converter words and the read data are 0x0000/0x00.
- R2: A write to 0x0D + 8·n loads the low byte and a write to 0x0E + 8·n loads the high byte of channel n's holding word; neither write changes any converter word.
- R3: A write to 0x0B + 8·n copies channel n's holding word to converter word n at that write's clock edge and leaves the other channel's converter word unchanged.
- R4: The data byte written with any strobe has no effect on the value loaded.
- R5: A write to 0x1B loads every present channel from its holding word on the same clock edge.
- R6: A read of offset 0x00 returns 0xE3 in the two-channel build and 0xE2 in the one-channel build; read data appears in the cycle after the read request and holds until the next read.
- R7: A read of any offset other than 0x00 returns 0x00, including the holding and strobe offsets.
- R8: In the one-channel build, converter word 1 stays 0x0000 whatever is written to 0x13, 0x15, 0x16 or 0x1B.
- R9: Writes to offsets outside the decoded set change neither holding words nor converter words.
- R10: A holding word keeps its value after a strobe, so a later write of only one byte followed by a strobe loads that new byte together with the byte already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write request for this cycle |
| rd_en | input | 1 | Byte read request for this cycle |
| addr | input | 8 | Offset within the module window |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| dac_word_0 | output | 16 | Converter word, channel 0 (two's complement) |
| dac_word_1 | output | 16 | Converter word, channel 1 (two's complement) |

## Verification
The bench reads every one of the 256 offsets in both builds. An identification byte that ignored the build parameter, or a decoder that leaked holding bytes onto the read path, shows up there as a wrong byte. For sixteen computed word pairs it checks that both outputs stay put after the byte writes and that only the strobed channel moves, with the strobe data byte set to a value unrelated to the word. A design that loaded on the byte write, or that took the strobe byte as data, would therefore change the wrong output or load the wrong value. It writes to every undecoded offset and then fires the shared strobe, which exposes a loose address compare, and it checks that the one-channel build keeps its second output at zero. A final single-byte update checks that the other byte of the holding word was kept.

// File: rtl/dacif_pkg.sv
// Package: dacif_pkg
// Shared widths, offset map constants and the decoded-write type for the
// double-buffered converter register interface.
package dacif_pkg;

    localparam int ADDR_W     = 8;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int MAX_CH     = 2;

    // Per-channel offsets: base plus channel index times the stride.
    localparam int CH_STRIDE  = 8;
    localparam int STRB_BASE  = 'h0B;
    localparam int LO_BASE    = 'h0D;
    localparam int HI_BASE    = 'h0E;
    localparam int STRB_ALL   = 'h1B;
    localparam int ID_OFFSET  = 'h00;

    localparam logic [BYTE_W-1:0] ID_ONE_CH = 8'hE2;
    localparam logic [BYTE_W-1:0] ID_TWO_CH = 8'hE3;

    // One-hot-per-purpose write decode for a single bus cycle.
    typedef struct packed {
        logic [MAX_CH-1:0] lo_wr;
        logic [MAX_CH-1:0] hi_wr;
        logic [MAX_CH-1:0] strb;
        logic              strb_all;
    } wr_dec_t;

endpackage

// File: rtl/dacif_decode.sv
// Module: dacif_decode
// Turns a write request and offset into per-channel byte-load and strobe
// pulses. Channels at or above CHANNELS never decode, so their offsets are
// inert. Assumes at most one bus access per cycle.
module dacif_decode
    import dacif_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_dec_t           dec
);

    // Compare the offset against each present channel's three addresses.
    always_comb begin
        dec = '0;
        for (int ch = 0; ch < MAX_CH; ch++) begin
            if (ch < CHANNELS) begin
                dec.lo_wr[ch] = wr_en && (addr == ADDR_W'(LO_BASE   + CH_STRIDE * ch));
                dec.hi_wr[ch] = wr_en && (addr == ADDR_W'(HI_BASE   + CH_STRIDE * ch));
                dec.strb[ch]  = wr_en && (addr == ADDR_W'(STRB_BASE + CH_STRIDE * ch));
            end
        end
        dec.strb_all = wr_en && (addr == ADDR_W'(STRB_ALL));
    end

endmodule

// File: rtl/dacif_channel.sv
// Module: dacif_channel
// One converter channel: a holding word built from two byte registers and an
// active word loaded from the holding word on a load pulse. Assumes the
// byte-load pulses and the load pulse are never active in the same cycle.
module dacif_channel
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              load,
    output logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] active_word
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Capture the low and high staging bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_wr) lo_q <= wdata;
            if (hi_wr) hi_q <= wdata;
        end
    end

    assign hold_word = {hi_q, lo_q};

    // Transfer the staged word to the converter on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_word <= '0;
        end else if (load) begin
            active_word <= hold_word;
        end
    end

endmodule

// File: rtl/dacif_readback.sv
// Module: dacif_readback
// Registered read path: the identification byte at its offset, zero for
// every other offset. The result holds until the next read request.
module dacif_readback
    import dacif_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_BYTE = ID_TWO_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rdata
);

    // Register the selected read byte on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= (addr == ADDR_W'(ID_OFFSET)) ? ID_BYTE : '0;
        end
    end

endmodule

// File: rtl/dac_bank_regif.sv
// Module: dac_bank_regif
// Byte-wide register front end for one or two double-buffered 16-bit
// converter channels. CHANNELS picks the build (1 or 2) and therefore the
// identification byte. Channel slots beyond CHANNELS drive zero.
module dac_bank_regif
    import dacif_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] dac_word_0,
    output logic [WORD_W-1:0] dac_word_1
);

    localparam logic [BYTE_W-1:0] ID_BYTE = (CHANNELS >= 2) ? ID_TWO_CH : ID_ONE_CH;

    wr_dec_t           dec;
    logic [WORD_W-1:0] hold_w   [MAX_CH];
    logic [WORD_W-1:0] active_w [MAX_CH];

    dacif_decode #(
        .CHANNELS (CHANNELS)
    ) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .dec   (dec)
    );

    for (genvar ch = 0; ch < MAX_CH; ch++) begin : g_ch
        if (ch < CHANNELS) begin : g_present
            dacif_channel u_channel (
                .clk         (clk),
                .rst_n       (rst_n),
                .wdata       (wdata),
                .lo_wr       (dec.lo_wr[ch]),
                .hi_wr       (dec.hi_wr[ch]),
                .load        (dec.strb[ch] | dec.strb_all),
                .hold_word   (hold_w[ch]),
                .active_word (active_w[ch])
            );
        end else begin : g_absent
            assign hold_w[ch]   = '0;
            assign active_w[ch] = '0;
        end
    end

    dacif_readback #(
        .ID_BYTE (ID_BYTE)
    ) u_readback (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .addr  (addr),
        .rdata (rdata)
    );

    assign dac_word_0 = active_w[0];
    assign dac_word_1 = active_w[1];

endmodule

// File: rtl/dac_bank_regif_checker.sv
// Module: dac_bank_regif_checker
// Port-level and staging-level properties of dac_bank_regif, bound to every
// instance. Holding words are observed only to relate them to the outputs.
module dac_bank_regif_checker
    import dacif_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] rdata,
    input logic [WORD_W-1:0] dac_word_0,
    input logic [WORD_W-1:0] dac_word_1,
    input logic [WORD_W-1:0] hold_0,
    input logic [WORD_W-1:0] hold_1
);

    localparam logic [BYTE_W-1:0] EXP_ID = (CHANNELS >= 2) ? ID_TWO_CH : ID_ONE_CH;

    logic ld0;
    logic ld1;
    assign ld0 = wr_en && (addr == ADDR_W'(STRB_BASE) || addr == ADDR_W'(STRB_ALL));
    assign ld1 = wr_en && (addr == ADDR_W'(STRB_BASE + CH_STRIDE) || addr == ADDR_W'(STRB_ALL));

    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(ID_OFFSET) |=> rdata == EXP_ID); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R6
    AST_UNDECODED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr != ADDR_W'(ID_OFFSET) |=> rdata == '0); // R7
    AST_CH0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld0 |=> dac_word_0 == $past(hold_0)); // R3
    AST_CH0_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !ld0 |=> $stable(dac_word_0)); // R2

    if (CHANNELS >= 2) begin : g_two
        AST_CH1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            ld1 |=> dac_word_1 == $past(hold_1)); // R5
        AST_CH1_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            !ld1 |=> $stable(dac_word_1)); // R2
    end else begin : g_one
        AST_CH1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> dac_word_1 == '0 && hold_1 == '0); // R8
    end

endmodule

bind dac_bank_regif dac_bank_regif_checker #(
    .CHANNELS (CHANNELS)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .rdata      (rdata),
    .dac_word_0 (dac_word_0),
    .dac_word_1 (dac_word_1),
    .hold_0     (hold_w[0]),
    .hold_1     (hold_w[1])
);

// File: tb/dac_bank_regif_bench.sv
// Bench for dac_bank_regif: a two-channel and a one-channel instance share
// one bus; expected words are tracked from the bus writes the bench makes.
module dac_bank_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata_two, rdata_one;
    logic [15:0] w0_two, w1_two, w0_one, w1_one;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Expected holding words (per build) and converter words.
    logic [15:0] h0 = '0, h1 = '0, e0 = '0, e1 = '0;

    always #4 clk = ~clk;

    dac_bank_regif #(.CHANNELS(2)) u_dac_bank_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_two), .dac_word_0(w0_two), .dac_word_1(w1_two)
    );

    dac_bank_regif #(.CHANNELS(1)) u_dac_bank_regif_one (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_one), .dac_word_0(w0_one), .dac_word_1(w1_one)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Both builds share channel 0 expectations; the one-channel build keeps word 1 at zero.
    task automatic chk_outs(input string req);
        chk({req, " two ch0"}, w0_two, e0);
        chk({req, " two ch1"}, w1_two, e1);
        chk({req, " one ch0"}, w0_one, e0);
        chk({req, " one ch1 R8"}, w1_one, 16'h0000);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_outs("R1 reset");
        chk("R1 reset rdata two", {8'h00, rdata_two}, 16'h0000);
        chk("R1 reset rdata one", {8'h00, rdata_one}, 16'h0000);

        // R6 / R7: read every offset in both builds
        for (int a = 0; a < 256; a++) begin
            rd(8'(a));
            chk("R6/R7 read two", {8'h00, rdata_two}, (a == 0) ? 16'h00E3 : 16'h0000);
            chk("R6/R7 read one", {8'h00, rdata_one}, (a == 0) ? 16'h00E2 : 16'h0000);
        end
        rd(8'h00);
        @(negedge clk);
        chk("R6 rdata holds two", {8'h00, rdata_two}, 16'h00E3);

        // R2 / R3 / R4 / R8: per-channel staging then strobe
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v, w;
            v = 16'(k * 16'h1357) ^ 16'hA0A0;
            w = ~v;
            wr(8'h0D, v[7:0]);  h0[7:0]  = v[7:0];
            wr(8'h0E, v[15:8]); h0[15:8] = v[15:8];
            chk_outs("R2 ch0 staged");
            wr(8'h0B, ~v[15:8]); e0 = h0;
            chk_outs("R3 R4 ch0 strobe");
            wr(8'h15, w[7:0]);  h1[7:0]  = w[7:0];
            wr(8'h16, w[15:8]); h1[15:8] = w[15:8];
            chk_outs("R2 ch1 staged");
            wr(8'h13, v[7:0]); e1 = h1;
            chk_outs("R3 R4 R8 ch1 strobe");
        end

        // R5: shared strobe loads both at once
        wr(8'h0D, 8'h34); wr(8'h0E, 8'h12); h0 = 16'h1234;
        wr(8'h15, 8'hCD); wr(8'h16, 8'hAB); h1 = 16'hABCD;
        chk_outs("R2 both staged");
        wr(8'h1B, 8'h5A); e0 = h0; e1 = h1;
        chk_outs("R5 R8 shared strobe");

        // R9: writes to undecoded offsets touch nothing
        for (int a = 0; a < 256; a++) begin
            if (!(a inside {8'h0B, 8'h0D, 8'h0E, 8'h13, 8'h15, 8'h16, 8'h1B}))
                wr(8'(a), 8'hFF);
        end
        chk_outs("R9 after undecoded writes");
        wr(8'h1B, 8'h00);
        chk_outs("R9 holding intact");

        // R10: one new byte combines with the retained byte
        wr(8'h0E, 8'h80); h0[15:8] = 8'h80;
        wr(8'h0B, 8'h00); e0 = h0;
        chk_outs("R10 ch0 partial");
        chk("R10 ch0 value", w0_two, 16'h8034);
        wr(8'h15, 8'h01); h1[7:0] = 8'h01;
        wr(8'h1B, 8'hEE); e0 = h0; e1 = h1;
        chk_outs("R10 R5 partial shared");
        chk("R10 ch1 value", w1_two, 16'hAB01);

        // R1: reset returns everything to mid-scale zero
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        e0 = '0; e1 = '0;
        @(negedge clk);
        chk_outs("R1 re-reset");
        wr(8'h1B, 8'h00);
        chk_outs("R1 holding cleared");

        summary();
    end

endmodule